// File: doc/BRIEF.md
# Indirect Multichannel Register Access Port

This block puts the internal registers of four processing channels behind a window of eight byte-wide host addresses. The host never addresses an internal register directly. It loads an 8-bit internal address into a pointer register and picks the target channel or channels in a control register. It then moves a word of up to 20 bits through three byte-wide data windows. The lowest data window is the trigger. Writing it commits the staged word to the internal register file. Reading it fetches an internal word, whose upper bytes are then available from the two other windows.

The control register can turn on a broadcast mode. In that mode a 4-bit instruction chooses a group of channels, or a subset of devices by their ID pins, and one host write reaches every selected channel at once. The pointer can also step by one after each trigger access, so that a block of consecutive internal registers can be streamed without reloading the address. A map-select bit sends accesses to an alternate I/O port control map in place of the normal channel map.

Top module: `chan_access_port`

## Requirements
- R1: After reset, reg_we is 0, reg_re is 0, host_rdata is 0, and the pointer, control and map-select registers read back as 0.
- R2: Writes to host address 1 and host address 2 only stage bytes. Of the byte written to address 2, bits 7:4 are ignored. A write to host address 0 drives reg_we for exactly one cycle, starting the cycle after the strobe. reg_wdata is then {addr2[3:0], addr1, addr0}.
- R3: Internal accesses carry the pointer register (host address 6) on reg_addr. reg_alt_map carries bit 5 of the map-select register (host address 3).
- R4: The control register is at host address 7. Its fields are: bit 7 auto-step, bit 6 broadcast, bits 5:2 instruction, bits 1:0 channel. With broadcast at 0, exactly the channel in bits 1:0 is enabled and the instruction is ignored.
- R5: With broadcast at 1, the instruction selects the channels as follows. 0000 enables all four channels. 0001 enables channels 0 to 2. 0010 enables channels 1 to 3. 0100 enables the channel in bits 1:0. Every code not listed under R5 or R6 enables none.
- R6: With broadcast at 1, the device-subset codes enable the channel in bits 1:0 only when dev_id matches. Code 1000 needs dev_id[0]=0. Code 1001 needs dev_id[0]=1. Codes 11xy need dev_id[1:0]=xy. On a mismatch no channel is enabled.
- R7: A host read of address 0 with broadcast at 0 pulses reg_re for one cycle, starting the cycle after the strobe. During that pulse reg_rsel is control bits 1:0. reg_rdata[7:0] appears on host_rdata two cycles after the strobe. Later reads of addresses 1 and 2 return word bits 15:8, and word bits 19:16 with zeros above them.
- R8: With auto-step at 1, every access to host address 0, read or write, advances the pointer by one, and 255 wraps to 0. With auto-step at 0 the pointer does not change.
- R9: With broadcast at 1, reads of host addresses 0, 1, 2 and 6 return 0, and a read of address 0 issues no reg_re.
- R10: Reads of addresses 3, 6 and 7 return the register one cycle after the strobe. Writes to addresses 4 and 5 are ignored, and reads of them return 0.
- R11: When host_wr and host_rd are high together, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | 2 | Device ID bits used for subset decode |
| host_addr | input | 3 | Host window address |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_rdata | output | 8 | Registered host read byte |
| reg_addr | output | 8 | Internal register address |
| reg_alt_map | output | 1 | Selects the alternate I/O port control map |
| reg_wdata | output | 20 | Internal write word |
| reg_we | output | 4 | Per-channel internal write enables |
| reg_re | output | 1 | Internal read strobe |
| reg_rsel | output | 2 | Channel being read |
| reg_rdata | input | 20 | Internal read word, valid while reg_re is high |

## Verification
A write to the trigger window shows up on reg_we, reg_addr and reg_wdata one cycle after the strobe edge. The bench drives on the falling edge and samples at the next falling edge, so the commit is read in the only cycle it is present. Register readback and the zero returned in broadcast mode are due one cycle after the strobe. The trigger read comes back one cycle later because the fetched word passes through reg_re, so the bench waits one more falling edge for it and checks reg_re at the intermediate edge. Reads of the upper windows are issued only after the fetch has landed.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int NCH  = 4;
    localparam int CHW  = $clog2(NCH);
    localparam int BW   = 8;
    localparam int DW   = 20;
    localparam int HW   = DW - 2 * BW;
    localparam int AW   = 8;
    localparam int EAW  = 3;
    localparam int IW   = 4;
    localparam int IDW  = 2;

    // host window addresses
    localparam logic [EAW-1:0] A_TRIG = 3'd0;
    localparam logic [EAW-1:0] A_MID  = 3'd1;
    localparam logic [EAW-1:0] A_HI   = 3'd2;
    localparam logic [EAW-1:0] A_MAP  = 3'd3;
    localparam logic [EAW-1:0] A_PTR  = 3'd6;
    localparam logic [EAW-1:0] A_CTL  = 3'd7;

    // control register fields
    localparam int CTL_STEP = 7;
    localparam int CTL_BC   = 6;
    localparam int CTL_IHI  = 5;
    localparam int CTL_ILO  = 2;
    localparam int MAP_BIT  = 5;

    typedef struct packed {
        logic [BW-1:0]  ctl;
        logic           alt;
        logic [NCH-1:0] we;
        logic           re;
        logic [CHW-1:0] rsel;
        logic [AW-1:0]  addr;
        logic           alt_o;
        logic [DW-1:0]  wdata;
        logic [BW-1:0]  rdata;
    } cap_state_t;

    typedef struct packed {
        logic [BW-1:0] mid;
        logic [HW-1:0] hi;
        logic [DW-1:0] hold;
    } cap_data_t;
endpackage

// File: rtl/cap_sel_decode.sv
module cap_sel_decode
    import cap_pkg::*;
(
    input  logic           bcast,
    input  logic [IW-1:0]  instr,
    input  logic [CHW-1:0] chan,
    input  logic [IDW-1:0] dev_id,
    output logic [NCH-1:0] sel
);
    logic [NCH-1:0] one_ch;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_one
            assign one_ch[g] = (chan == CHW'(g));
        end
    endgenerate

    always_comb begin
        sel = '0;
        if (!bcast) begin
            sel = one_ch;
        end else begin
            casez (instr)
                4'b0000: sel = '1;
                4'b0001: sel = 4'b0111;
                4'b0010: sel = 4'b1110;
                4'b0100: sel = one_ch;
                4'b1000: sel = dev_id[0] ? '0 : one_ch;
                4'b1001: sel = dev_id[0] ? one_ch : '0;
                4'b11??: sel = (dev_id == instr[1:0]) ? one_ch : '0;
                default: sel = '0;
            endcase
        end
    end
endmodule

// File: rtl/cap_addr_ctr.sv
module cap_addr_ctr
    import cap_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load)
            ptr_d = load_val;
        else if (step)
            ptr_d = ptr_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (ptr == AW'($past(ptr) + AW'(1))));      // R8
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(ptr));                          // R8
endmodule

// File: rtl/cap_data_path.sv
module cap_data_path
    import cap_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_mid,
    input  logic          ld_hi,
    input  logic [BW-1:0] wbyte,
    input  logic          capture,
    input  logic [DW-1:0] cap_word,
    output logic [BW-1:0] stage_mid,
    output logic [HW-1:0] stage_hi,
    output logic [DW-1:0] hold
);
    cap_data_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ld_mid)  s_d.mid  = wbyte;
        if (ld_hi)   s_d.hi   = wbyte[HW-1:0];
        if (capture) s_d.hold = cap_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stage_mid = s_q.mid;
    assign stage_hi  = s_q.hi;
    assign hold      = s_q.hold;

    AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_mid && !ld_hi) |=> ($stable(stage_mid) && $stable(stage_hi))); // R2
endmodule

// File: rtl/chan_access_port.sv
module chan_access_port
    import cap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      dev_id,
    input  logic [2:0]      host_addr,
    input  logic [7:0]      host_wdata,
    input  logic            host_wr,
    input  logic            host_rd,
    output logic [7:0]      host_rdata,
    output logic [7:0]      reg_addr,
    output logic            reg_alt_map,
    output logic [19:0]     reg_wdata,
    output logic [3:0]      reg_we,
    output logic            reg_re,
    output logic [1:0]      reg_rsel,
    input  logic [19:0]     reg_rdata
);
    cap_state_t s_d, s_q;

    logic           wr_go, rd_go, trig_acc, bcast;
    logic [NCH-1:0] sel;
    logic [AW-1:0]  ptr;
    logic [BW-1:0]  stage_mid;
    logic [HW-1:0]  stage_hi;
    logic [DW-1:0]  hold;

    assign wr_go    = host_wr;
    assign rd_go    = host_rd && !host_wr;
    assign trig_acc = (wr_go || rd_go) && (host_addr == A_TRIG);
    assign bcast    = s_q.ctl[CTL_BC];

    cap_sel_decode u_dec (
        .bcast  (bcast),
        .instr  (s_q.ctl[CTL_IHI:CTL_ILO]),
        .chan   (s_q.ctl[CHW-1:0]),
        .dev_id (dev_id),
        .sel    (sel)
    );

    cap_addr_ctr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_go && host_addr == A_PTR),
        .load_val (host_wdata),
        .step     (trig_acc && s_q.ctl[CTL_STEP]),
        .ptr      (ptr)
    );

    cap_data_path u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_mid    (wr_go && host_addr == A_MID),
        .ld_hi     (wr_go && host_addr == A_HI),
        .wbyte     (host_wdata),
        .capture   (s_q.re),
        .cap_word  (reg_rdata),
        .stage_mid (stage_mid),
        .stage_hi  (stage_hi),
        .hold      (hold)
    );

    always_comb begin
        s_d    = s_q;
        s_d.we = '0;
        s_d.re = 1'b0;

        // landing of a fetch issued in the previous cycle
        if (s_q.re)
            s_d.rdata = reg_rdata[BW-1:0];

        if (wr_go) begin
            case (host_addr)
                A_CTL: s_d.ctl = host_wdata;
                A_MAP: s_d.alt = host_wdata[MAP_BIT];
                A_TRIG: begin
                    s_d.we    = sel;
                    s_d.addr  = ptr;
                    s_d.alt_o = s_q.alt;
                    s_d.wdata = {stage_hi, stage_mid, host_wdata};
                end
                default: ;
            endcase
        end else if (rd_go) begin
            case (host_addr)
                A_TRIG: begin
                    s_d.rdata = '0;
                    if (!bcast) begin
                        s_d.re    = 1'b1;
                        s_d.rsel  = s_q.ctl[CHW-1:0];
                        s_d.addr  = ptr;
                        s_d.alt_o = s_q.alt;
                    end
                end
                A_MID:   s_d.rdata = bcast ? '0 : hold[2*BW-1:BW];
                A_HI:    s_d.rdata = bcast ? '0 : {{(BW-HW){1'b0}}, hold[DW-1:2*BW]};
                A_PTR:   s_d.rdata = bcast ? '0 : ptr;
                A_CTL:   s_d.rdata = s_q.ctl;
                A_MAP: begin
                    s_d.rdata          = '0;
                    s_d.rdata[MAP_BIT] = s_q.alt;
                end
                default: s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign host_rdata  = s_q.rdata;
    assign reg_addr    = s_q.addr;
    assign reg_alt_map = s_q.alt_o;
    assign reg_wdata   = s_q.wdata;
    assign reg_we      = s_q.we;
    assign reg_re      = s_q.re;
    assign reg_rsel    = s_q.rsel;

    AST_WE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we != '0) |-> $past(host_wr && host_addr == A_TRIG));   // R2
    AST_SINGLE_CH: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_we != '0) && !$past(s_q.ctl[CTL_BC])) |-> $onehot(reg_we)); // R4
    AST_RE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> $past(host_rd && !host_wr && host_addr == A_TRIG
                         && !s_q.ctl[CTL_BC]));                      // R7
    AST_NO_ACCESS_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_re && (reg_we != '0)));                                // R11
    AST_BCAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_rd && !host_wr && s_q.ctl[CTL_BC] &&
              (host_addr == A_TRIG || host_addr == A_MID ||
               host_addr == A_HI   || host_addr == A_PTR))
        |-> (host_rdata == '0));                                     // R9
endmodule

// File: tb/chan_access_port_bench.sv
`timescale 1ns/1ps
module chan_access_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  dev_id = '0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic [7:0]  reg_addr;
    logic        reg_alt_map;
    logic [19:0] reg_wdata;
    logic [3:0]  reg_we;
    logic        reg_re;
    logic [1:0]  reg_rsel;
    logic [19:0] reg_rdata;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    chan_access_port u_chan_access_port (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .reg_addr(reg_addr), .reg_alt_map(reg_alt_map),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rsel(reg_rsel), .reg_rdata(reg_rdata)
    );

    // model of the internal register file: [map][channel][address]
    logic [19:0] mem [0:1][0:3][0:255];
    initial begin
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 4; c++)
                for (int a = 0; a < 256; a++)
                    mem[m][c][a] = '0;
    end
    always @(posedge clk) begin
        for (int c = 0; c < 4; c++)
            if (reg_we[c]) mem[reg_alt_map][c][reg_addr] <= reg_wdata;
    end
    assign reg_rdata = reg_re ? mem[reg_alt_map][reg_rsel][reg_addr] : 20'h0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        if (a == 3'd0) @(negedge clk);
        d = host_rdata;
    endtask

    task automatic put_word(input logic [19:0] w, input logic [7:0] junk);
        do_wr(3'd2, {junk[7:4], w[19:16]});
        do_wr(3'd1, w[15:8]);
        do_wr(3'd0, w[7:0]);
    endtask

    typedef struct packed {
        logic [1:0]  id;
        logic [7:0]  ctl;
        logic [7:0]  ptr;
        logic [19:0] data;
        logic [3:0]  mask;
    } vec_t;

    // ctl: [7] auto-step [6] broadcast [5:2] instruction [1:0] channel
    localparam vec_t VECS [12] = '{
        '{2'b00, 8'h02, 8'h11, 20'h12345, 4'b0100},   // R4 instr ignored
        '{2'b00, 8'h3F, 8'h22, 20'hABCDE, 4'b1000},   // R4
        '{2'b00, 8'h41, 8'h33, 20'h0F0F0, 4'b1111},   // R5 all
        '{2'b00, 8'h44, 8'h44, 20'h11111, 4'b0111},   // R5 low three
        '{2'b00, 8'h48, 8'h55, 20'h22222, 4'b1110},   // R5 high three
        '{2'b01, 8'h52, 8'h66, 20'h33333, 4'b0100},   // R5 per chan
        '{2'b10, 8'h63, 8'h77, 20'h44444, 4'b1000},   // R6 id0=0 match
        '{2'b11, 8'h63, 8'h88, 20'h55555, 4'b0000},   // R6 mismatch
        '{2'b11, 8'h64, 8'h99, 20'h66666, 4'b0001},   // R6 id0=1
        '{2'b10, 8'h79, 8'hAA, 20'h77777, 4'b0010},   // R6 id=10
        '{2'b10, 8'h75, 8'hBB, 20'h88888, 4'b0000},   // R6 id!=01
        '{2'b00, 8'h4C, 8'hCC, 20'h99999, 4'b0000}    // R5 undefined
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reg_we", {28'h0, reg_we}, 0);
        chk("R1 reg_re", {31'h0, reg_re}, 0);
        chk("R1 host_rdata", {24'h0, host_rdata}, 0);
        rst_n = 1'b1;
        do_rd(3'd6, rb); chk("R1 pointer", {24'h0, rb}, 0);
        do_rd(3'd7, rb); chk("R1 control", {24'h0, rb}, 0);
        do_rd(3'd3, rb); chk("R1 map", {24'h0, rb}, 0);

        // table: selection and commit
        foreach (VECS[i]) begin
            dev_id = VECS[i].id;
            do_wr(3'd7, VECS[i].ctl);
            do_wr(3'd6, VECS[i].ptr);
            put_word(VECS[i].data, 8'hA0);
            chk("R5/R6 select", {28'h0, reg_we}, {28'h0, VECS[i].mask});
            chk("R3 address", {24'h0, reg_addr}, {24'h0, VECS[i].ptr});
            chk("R2 word", {12'h0, reg_wdata}, {12'h0, VECS[i].data});
            @(negedge clk);
            chk("R2 single pulse", {28'h0, reg_we}, 0);
        end
        dev_id = 2'b00;

        // R7 readback on channel 1
        do_wr(3'd7, 8'h01);
        do_wr(3'd6, 8'h10);
        put_word(20'h5A5C3, 8'hF0);
        do_wr(3'd6, 8'h10);
        @(negedge clk); host_addr = 3'd0; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
        chk("R7 reg_re", {31'h0, reg_re}, 1);
        chk("R7 reg_rsel", {30'h0, reg_rsel}, 1);
        @(negedge clk);
        chk("R7 low byte", {24'h0, host_rdata}, 32'hC3);
        chk("R7 re drop", {31'h0, reg_re}, 0);
        do_rd(3'd1, rb); chk("R7 mid byte", {24'h0, rb}, 32'hA5);
        do_rd(3'd2, rb); chk("R7 top bits", {24'h0, rb}, 32'h05);

        // R3 alternate map
        do_wr(3'd3, 8'h20);
        do_rd(3'd3, rb); chk("R10 map read", {24'h0, rb}, 32'h20);
        put_word(20'h00077, 8'h00);
        chk("R3 alt flag", {31'h0, reg_alt_map}, 1);
        do_rd(3'd0, rb); chk("R3 alt read", {24'h0, rb}, 32'h77);
        do_wr(3'd3, 8'h00);
        do_rd(3'd0, rb); chk("R3 normal map", {24'h0, rb}, 32'hC3);

        // R8 auto-step with wrap
        do_wr(3'd7, 8'h80);
        do_wr(3'd6, 8'hFE);
        put_word(20'h00001, 8'h00);
        chk("R8 step 0", {24'h0, reg_addr}, 32'hFE);
        do_wr(3'd0, 8'h02);
        chk("R8 step 1", {24'h0, reg_addr}, 32'hFF);
        do_wr(3'd0, 8'h03);
        chk("R8 wrap", {24'h0, reg_addr}, 32'h00);
        do_rd(3'd0, rb);
        do_rd(3'd6, rb); chk("R8 after read", {24'h0, rb}, 32'h02);
        do_wr(3'd7, 8'h00);
        do_wr(3'd0, 8'h04);
        do_rd(3'd6, rb); chk("R8 no step", {24'h0, rb}, 32'h02);

        // R9 broadcast readback
        do_wr(3'd7, 8'h41);
        @(negedge clk); host_addr = 3'd0; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
        chk("R9 no fetch", {31'h0, reg_re}, 0);
        chk("R9 trig zero", {24'h0, host_rdata}, 0);
        do_rd(3'd1, rb); chk("R9 mid zero", {24'h0, rb}, 0);
        do_rd(3'd6, rb); chk("R9 ptr zero", {24'h0, rb}, 0);
        do_rd(3'd7, rb); chk("R10 ctl read", {24'h0, rb}, 32'h41);

        // R10 unused addresses
        do_wr(3'd7, 8'h00);
        do_wr(3'd4, 8'hFF);
        do_rd(3'd4, rb); chk("R10 addr4", {24'h0, rb}, 0);
        do_wr(3'd5, 8'hFF);
        do_rd(3'd5, rb); chk("R10 addr5", {24'h0, rb}, 0);
        do_rd(3'd7, rb); chk("R10 ctl intact", {24'h0, rb}, 0);

        // R11 write wins over read
        do_rd(3'd7, rb);
        @(negedge clk);
        host_addr = 3'd6; host_wdata = 8'h33; host_wr = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        chk("R11 no read data", {24'h0, host_rdata}, 0);
        do_rd(3'd6, rb); chk("R11 write done", {24'h0, rb}, 32'h33);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule